// File: doc/BRIEF.md
# Audio Codec Sample Streamer

This block carries audio samples between sample FIFOs and a stereo serial codec. It divides the system clock into a bit clock and a left/right frame clock. Playback words are fetched from a synchronous FIFO and shifted out, most significant bit first. Two serial record inputs are shifted in and pushed into two record FIFOs. Playback and each record channel have their own mono/stereo select. Playback can be muted or replaced by a built-in square test tone.

The FIFO edges follow a flow-control rule in which the block decides when a transfer happens. On the playback side, a low empty flag means valid, and a one-cycle read strobe takes one word. The FIFO may return that word a long time after the strobe, because the block only latches it at the start of the following slot. On the record side the block never waits. A one-cycle write strobe marks a new word, and the word stays on its output until the next strobe of that channel. The FIFO must therefore accept one word per slot.

A slot is 16 bit periods, and a frame is two slots with left first. At the default of 71 system clocks per bit, one frame lasts 2272 clocks. That gives about 22 kHz from a 50 MHz clock.

Top module: `acs_streamer`

## Requirements
- R1: The bit clock has a period of BIT_CLKS system clocks. Each slot is 16 bits and each frame is two slots, so a frame lasts 32*BIT_CLKS clocks. The frame clock is low during the left slot and high during the right slot, and it changes only in the cycle the bit clock falls.
- R2: The serial output carries each slot word as 16-bit two's complement, most significant bit first. It changes as the bit clock falls and is stable at the bit clock's rising edge.
- R3: In stereo playback the block issues a one-cycle read strobe at the start of every slot, provided the FIFO is not empty. The word returned is played in the following slot.
- R4: In mono playback the block issues one read strobe per frame, at the start of the right slot. The word returned is played in both slots of the next frame.
- R5: No read strobe is issued while the FIFO empty flag is high. A slot for which no word was fetched plays zero, and playback resumes with the next fetch that finds data.
- R6: While mute is high the played words are zero, but read strobes are issued exactly as without mute.
- R7: While the tone input is high and mute is low, each slot plays a square wave instead of FIFO data. The wave is +0x2000 for TONE_FRAMES frames and then 0xE000 for TONE_FRAMES frames, starting positive after reset. Read strobes are unchanged.
- R8: A fetched playback word only has to be valid at the start of the slot after its strobe. At the default setting this tolerates a latency of up to 1135 clocks.
- R9: Each record input is sampled as the bit clock rises, most significant bit first.
- R10: A record channel in stereo issues one write strobe per slot. In mono it issues a strobe only for the left slot. The strobe comes in the cycle the last bit is sampled, and the data is held until that channel's next strobe. Each channel has its own mono/stereo select.
- R11: While reset is high, all strobes, the serial output, the bit clock and the frame clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| play_rd_o | output | 1 | One-cycle playback FIFO read strobe |
| play_data_i | input | 16 | Playback FIFO word |
| play_empty_i | input | 1 | Playback FIFO empty flag |
| play_stereo_i | input | 1 | Playback mode: 1 stereo, 0 mono |
| mute_i | input | 1 | Silence playback output |
| tone_i | input | 1 | Replace playback with test tone |
| rec_stereo_i | input | 2 | Record mode per channel: 1 stereo, 0 mono |
| rec_wr_o | output | 2 | One-cycle record FIFO write strobes, bit n for channel n |
| rec_data0_o | output | 16 | Record channel 0 word |
| rec_data1_o | output | 16 | Record channel 1 word |
| bclk_o | output | 1 | Codec bit clock |
| lrclk_o | output | 1 | Codec frame clock, low for left |
| sdout_o | output | 1 | Serial playback data |
| sdin_i | input | 2 | Serial record data, bit n for channel n |

## Verification
At every slot start, two actions fall in the same clock edge: the word from the previous read strobe is latched, and the next read strobe is issued. The bench provokes this with FIFO latencies from a few cycles up to just under a slot. Each slot captured on the serial pin must hold the word the requirements assign to it, even though the FIFO output changes only after the new strobe. Record write strobes also coincide with the last bit sample of a slot, so every pushed word is compared with the pattern that slot carried on the serial input.

// File: rtl/acs_pkg.sv
`timescale 1ns/100ps
package acs_pkg;
  localparam int ACS_W    = 16;
  localparam int ACS_IDXW = $clog2(2 * ACS_W);

  typedef logic [ACS_W-1:0] acs_word_t;

  typedef struct packed {
    logic                bit_start;
    logic                bit_sample;
    logic                frame_end;
    logic [ACS_IDXW-1:0] bit_idx;
  } acs_tick_t;
endpackage

// File: rtl/acs_timebase.sv
`timescale 1ns/100ps
module acs_timebase
  import acs_pkg::*;
#(
  parameter int BIT_CLKS = 71
) (
  input  logic      clk_i,
  input  logic      rst_i,
  output acs_tick_t tick_o,
  output logic      bclk_o,
  output logic      lrclk_o
);
  localparam int CW = $clog2(BIT_CLKS);
  localparam int HALF = BIT_CLKS / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);

  logic [CW-1:0]       cnt_q;
  logic [ACS_IDXW-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else begin
      bclk_o  <= (cnt_q >= CNT_HALF);
      lrclk_o <= idx_q[ACS_IDXW-1];
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    tick_o.bit_start  = (cnt_q == '0);
    tick_o.bit_sample = (cnt_q == CNT_HALF);
    tick_o.frame_end  = (cnt_q == CNT_LAST) && (idx_q == '1);
    tick_o.bit_idx    = idx_q;
  end

  // R1: frame clock moves only together with a falling bit clock
  p_lr_on_fall_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(lrclk_o) |-> $fell(bclk_o));
endmodule

// File: rtl/acs_play.sv
`timescale 1ns/100ps
module acs_play
  import acs_pkg::*;
#(
  parameter int        TONE_FRAMES = 32,
  parameter acs_word_t TONE_AMP    = 16'h2000
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  acs_tick_t tick_i,
  input  logic      stereo_i,
  input  logic      mute_i,
  input  logic      tone_i,
  input  logic      empty_i,
  input  acs_word_t data_i,
  output logic      rd_o,
  output logic      sdout_o
);
  localparam int TW = (TONE_FRAMES > 1) ? $clog2(TONE_FRAMES) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TONE_FRAMES - 1);

  logic          pend_q, tneg_q;
  logic [TW-1:0] tcnt_q;
  acs_word_t     hold_q, sh_q;

  logic      right, slot_first, take_new, issue;
  acs_word_t raw, tone_w, out_w;

  always_comb begin
    right      = tick_i.bit_idx[ACS_IDXW-1];
    slot_first = (tick_i.bit_idx[ACS_IDXW-2:0] == '0);
    take_new   = stereo_i | ~right;
    raw        = take_new ? (pend_q ? data_i : '0) : hold_q;
    issue      = (stereo_i | right) & ~empty_i;
    tone_w     = tneg_q ? acs_word_t'(-TONE_AMP) : TONE_AMP;
    out_w      = mute_i ? '0 : (tone_i ? tone_w : raw);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_o    <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
      sh_q    <= '0;
      sdout_o <= 1'b0;
      tcnt_q  <= '0;
      tneg_q  <= 1'b0;
    end else begin
      rd_o <= 1'b0;
      if (tick_i.frame_end) begin
        if (tcnt_q == T_LAST) begin
          tcnt_q <= '0;
          tneg_q <= ~tneg_q;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
      if (tick_i.bit_start) begin
        if (slot_first) begin
          hold_q  <= raw;
          pend_q  <= issue;
          rd_o    <= issue;
          sdout_o <= out_w[ACS_W-1];
          sh_q    <= out_w << 1;
        end else begin
          sdout_o <= sh_q[ACS_W-1];
          sh_q    <= sh_q << 1;
        end
      end
    end
  end

  // R5: a strobe never follows a cycle with the empty flag high
  p_no_rd_empty_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_o |-> !$past(empty_i));
  // R3: read strobe lasts exactly one cycle
  p_rd_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_o |=> !rd_o);
  // R2: serial output only moves at a bit start
  p_sdout_edge_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sdout_o) |-> $past(tick_i.bit_start));
endmodule

// File: rtl/acs_rec.sv
`timescale 1ns/100ps
module acs_rec
  import acs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  acs_tick_t tick_i,
  input  logic      stereo_i,
  input  logic      sdin_i,
  output logic      wr_o,
  output acs_word_t data_o
);
  acs_word_t sh_q;
  logic      slot_last, right;

  always_comb begin
    right     = tick_i.bit_idx[ACS_IDXW-1];
    slot_last = (tick_i.bit_idx[ACS_IDXW-2:0] == '1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '0;
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (tick_i.bit_sample) begin
        sh_q <= {sh_q[ACS_W-2:0], sdin_i};
        if (slot_last && (stereo_i || !right)) begin
          wr_o   <= 1'b1;
          data_o <= {sh_q[ACS_W-2:0], sdin_i};
        end
      end
    end
  end

  // R10: pushed word held between strobes
  p_rec_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_o |-> $stable(data_o));
  // R10: strobe is a single-cycle pulse
  p_rec_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_o |=> !wr_o);
endmodule

// File: rtl/acs_streamer.sv
`timescale 1ns/100ps
module acs_streamer
  import acs_pkg::*;
#(
  parameter int BIT_CLKS    = 71,
  parameter int TONE_FRAMES = 32
) (
  input  logic        clk_i,
  input  logic        rst_i,
  output logic        play_rd_o,
  input  logic [15:0] play_data_i,
  input  logic        play_empty_i,
  input  logic        play_stereo_i,
  input  logic        mute_i,
  input  logic        tone_i,
  input  logic [1:0]  rec_stereo_i,
  output logic [1:0]  rec_wr_o,
  output logic [15:0] rec_data0_o,
  output logic [15:0] rec_data1_o,
  output logic        bclk_o,
  output logic        lrclk_o,
  output logic        sdout_o,
  input  logic [1:0]  sdin_i
);
  localparam int NREC = 2;

  acs_tick_t tick;
  acs_word_t rec_data [NREC];

  acs_timebase #(.BIT_CLKS(BIT_CLKS)) u_tb (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o)
  );

  acs_play #(.TONE_FRAMES(TONE_FRAMES)) u_play (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
    .stereo_i(play_stereo_i), .mute_i(mute_i), .tone_i(tone_i),
    .empty_i(play_empty_i), .data_i(play_data_i),
    .rd_o(play_rd_o), .sdout_o(sdout_o)
  );

  for (genvar ch = 0; ch < NREC; ch++) begin : g_rec
    acs_rec u_rec (
      .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
      .stereo_i(rec_stereo_i[ch]), .sdin_i(sdin_i[ch]),
      .wr_o(rec_wr_o[ch]), .data_o(rec_data[ch])
    );
  end

  assign rec_data0_o = rec_data[0];
  assign rec_data1_o = rec_data[1];

  // R11: nothing strobes in the cycle right after a reset cycle
  p_quiet_after_reset_r11: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!play_rd_o && rec_wr_o == 2'b00));
endmodule

// File: tb/tb_acs_streamer.sv
`timescale 1ns/100ps
module tb_acs_streamer;
  localparam int BITC = 4;
  localparam int TONEF = 2;
  localparam int NSLOT = 12;
  localparam int NSC = 7;

  typedef struct packed {
    logic       st;
    logic       mu;
    logic       tn;
    logic [1:0] rst2;
    logic [7:0] nw;
    logic [7:0] lat;
  } scen_t;

  // stereo, mute, tone, record modes, FIFO words, FIFO latency
  localparam scen_t SC [NSC] = '{
    '{1'b1, 1'b0, 1'b0, 2'b11, 8'd20, 8'd3},
    '{1'b0, 1'b0, 1'b0, 2'b00, 8'd20, 8'd40},
    '{1'b1, 1'b0, 1'b0, 2'b01, 8'd5,  8'd1},
    '{1'b1, 1'b1, 1'b0, 2'b10, 8'd20, 8'd10},
    '{1'b1, 1'b0, 1'b1, 2'b11, 8'd20, 8'd60},
    '{1'b0, 1'b1, 1'b1, 2'b01, 8'd20, 8'd5},
    '{1'b0, 1'b0, 1'b0, 2'b10, 8'd3,  8'd60}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        play_rd, play_empty, play_stereo = 1'b1, mute = 1'b0, tone = 1'b0;
  logic [15:0] play_data;
  logic [1:0]  rec_stereo = 2'b11, rec_wr, sdin;
  logic [15:0] rec_d0, rec_d1;
  logic        bclk, lrclk, sdout;

  int total = 0;
  int bad = 0;
  int nw_cfg = 0;
  int lat_cfg = 1;

  always #2.5 clk = ~clk;

  acs_streamer #(.BIT_CLKS(BITC), .TONE_FRAMES(TONEF)) dut (
    .clk_i(clk), .rst_i(rst), .play_rd_o(play_rd), .play_data_i(play_data),
    .play_empty_i(play_empty), .play_stereo_i(play_stereo), .mute_i(mute),
    .tone_i(tone), .rec_stereo_i(rec_stereo), .rec_wr_o(rec_wr),
    .rec_data0_o(rec_d0), .rec_data1_o(rec_d1), .bclk_o(bclk),
    .lrclk_o(lrclk), .sdout_o(sdout), .sdin_i(sdin)
  );

  function automatic logic [15:0] word_of(int i);
    return 16'(32'h8001 + i * 32'h1357);
  endfunction

  function automatic logic [15:0] rec_of(int ch, int s);
    logic [15:0] w;
    w = 16'(32'h3C5A + s * 32'h0F1D);
    return (ch != 0) ? ~w : w;
  endfunction

  function automatic logic [15:0] tone_of(int f);
    return (((f / TONEF) % 2) == 0) ? 16'h2000 : 16'hE000;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // codec and FIFO model
  int          cap, rp, lcnt, nrd, cyc, last_rise;
  int          nwr [2];
  logic        prev_b, prev_lr;
  logic [15:0] shc;
  logic [15:0] got [NSLOT+2];

  assign play_empty = (rp >= nw_cfg);

  always @(negedge clk) begin
    if (rst) begin
      cap = 0; rp = 0; lcnt = 0; nrd = 0; cyc = 0; last_rise = -1;
      nwr[0] = 0; nwr[1] = 0; prev_b = 1'b0; prev_lr = 1'b0; shc = '0;
      play_data = 16'hDEAD;
      sdin[0] = rec_of(0, 0)[15];
      sdin[1] = rec_of(1, 0)[15];
    end else begin
      cyc++;
      if (lrclk && !prev_lr) begin
        if (last_rise >= 0)
          check(cyc - last_rise == 32 * BITC, "R1 frame length", cyc - last_rise, 32 * BITC);
        last_rise = cyc;
      end
      prev_lr = lrclk;
      if (bclk && !prev_b) begin
        if (cap % 16 == 0)
          check(lrclk == 1'((cap / 16) % 2), "R1 frame clock level", int'(lrclk), (cap / 16) % 2);
        shc = {shc[14:0], sdout};
        if (cap % 16 == 15 && cap / 16 < NSLOT + 2) got[cap / 16] = shc;
        cap++;
        sdin[0] = rec_of(0, cap / 16)[15 - cap % 16];
        sdin[1] = rec_of(1, cap / 16)[15 - cap % 16];
      end
      prev_b = bclk;
      for (int ch = 0; ch < 2; ch++) begin
        if (rec_wr[ch]) begin
          logic [15:0] d;
          int s;
          d = (ch == 0) ? rec_d0 : rec_d1;
          s = cap / 16 - 1;
          nwr[ch]++;
          check(d == rec_of(ch, s), "R9 record word", int'(d), int'(rec_of(ch, s)));
          check(rec_stereo[ch] || (s % 2 == 0), "R10 mono record slot", s % 2, 0);
        end
      end
      if (play_rd) begin
        nrd++;
        rp++;
        lcnt = lat_cfg;
        play_data = 16'hDEAD;
      end else if (lcnt > 0) begin
        lcnt--;
        if (lcnt == 0) play_data = word_of(rp - 1);
      end
    end
  end

  initial begin
    int guard;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(!play_rd && rec_wr == 2'b00, "R11 strobes in reset", int'({play_rd, rec_wr}), 0);
    check(!bclk && !lrclk && !sdout, "R11 clocks in reset", int'({bclk, lrclk, sdout}), 0);

    for (int k = 0; k < NSC; k++) begin
      rst = 1'b1;
      play_stereo = SC[k].st; mute = SC[k].mu; tone = SC[k].tn;
      rec_stereo = SC[k].rst2; nw_cfg = int'(SC[k].nw); lat_cfg = int'(SC[k].lat);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      guard = 0;
      while (cap < NSLOT * 16 && guard < 20000) begin
        @(posedge clk);
        guard++;
      end
      if (guard >= 20000) check(1'b0, "watchdog", guard, 0);
      for (int s = 0; s < NSLOT; s++) begin
        logic [15:0] raw, exp;
        int f;
        f = s / 2;
        if (SC[k].st) raw = (s >= 1 && s - 1 < nw_cfg) ? word_of(s - 1) : 16'h0; // R3 R5
        else          raw = (f >= 1 && f - 1 < nw_cfg) ? word_of(f - 1) : 16'h0; // R4 R5
        exp = SC[k].mu ? 16'h0 : (SC[k].tn ? tone_of(f) : raw);                 // R6 R7
        check(got[s] == exp, "R2 R3 R4 R5 R6 R7 R8 slot word", int'(got[s]), int'(exp));
      end
      begin
        int er;
        er = SC[k].st ? ((nw_cfg < NSLOT) ? nw_cfg : NSLOT)
                      : ((nw_cfg < NSLOT / 2) ? nw_cfg : NSLOT / 2);
        check(nrd == er, "R3 R4 R5 R6 read strobe count", nrd, er);
        for (int ch = 0; ch < 2; ch++) begin
          int ew;
          ew = rec_stereo[ch] ? NSLOT : NSLOT / 2;
          check(nwr[ch] == ew, "R10 write strobe count", nwr[ch], ew);
        end
      end
      @(negedge clk);
    end

    // R11: reset in mid-run returns to quiet state
    rst = 1'b0;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!play_rd && !sdout && !bclk && !lrclk, "R11 mid-run reset", int'({play_rd, sdout, bclk, lrclk}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule